// File: doc/BRIEF.md
# USB Power Control Register

This block holds the single byte that governs power and connection behaviour in a dual-role USB controller. Software reaches it through a byte-wide register port made of a write strobe, an address, write data and read data. Controller hardware feeds it status events: bus reset present, reset completion with the negotiated speed, and suspend entry and exit. The block drives the control levels the rest of the controller needs: line enable, hi-speed permission, resume request, suspend permission, the isochronous SOF-wait policy and, in host role, the bus-reset drive.

Which bits software may change depends on the role input. Some bits exist only in device role. Hardware-owned bits cannot be written. When a hardware event and a software write hit the same bit in one cycle, the hardware event wins. A write-protect input turns any write into a rejected access, which is flagged by a one-cycle error pulse.

Top module: `usbpwr_ctl_reg`

## Requirements
- R1: After synchronous reset, the read data is 0x20 (only bit 5 set), `wr_err` is 0 and `drive_bus_rst` is 0.
- R2: An accepted write takes effect at the next edge. In device role (`host_role`=0), bits 7, 6, 5, 2 and 0 take the written value, and bits 4, 3 and 1 ignore the write data.
- R3: In host role (`host_role`=1), bits 7 and 6 read 0 and ignore writes. At any edge where `host_role` is 1, both bits are forced to 0.
- R4: Bit 3 is bus reset. In device role it is loaded at each edge from `bus_rst_active`. In host role only software writes it, and `drive_bus_rst` is high when the registered role is host and bit 3 is 1.
- R5: Bit 4 is hi-speed status and software cannot write it. In device role it loads `hs_granted` at an edge where `bus_rst_done` is 1. In host role it loads `hs_granted` at the edge where a write changes bit 3 from 1 to 0. Otherwise it holds.
- R6: Bit 1 is suspend status. In device role `susp_enter` sets it and software cannot write it. In host role, writing 1 to bit 1 sets it and writing 0 leaves it unchanged. `susp_exit` clears it in either role.
- R7: A write to the register address while `wr_lock` is 1 changes no bit, and `wr_err` is 1 for exactly the following cycle.
- R8: A write to any address other than `REG_ADDR` (default 0x1001) changes nothing and raises no error.
- R9: The outputs mirror the register bits: `iso_sof_wait` is bit 7, `line_en` is bit 6, `hs_allow` is bit 5, `resume_req` is bit 2 and `susp_allow` is bit 0.
- R10: Hardware takes priority over software on the same bit in the same cycle. A host write of 1 to bit 1 together with `susp_exit` leaves bit 1 at 0, and a device write never overrides bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_role | input | 1 | 1 = host role, 0 = device role |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Current register value |
| wr_lock | input | 1 | Write protection active |
| bus_rst_active | input | 1 | Reset signalling seen on the bus |
| bus_rst_done | input | 1 | Pulse: bus reset completed (device role) |
| hs_granted | input | 1 | Hi-speed negotiation result |
| susp_enter | input | 1 | Pulse: suspend entered (device role) |
| susp_exit | input | 1 | Pulse: suspend left |
| wr_err | output | 1 | One-cycle pulse after a blocked write |
| line_en | output | 1 | Enables the D+/D- drivers |
| hs_allow | output | 1 | Hi-speed negotiation permitted |
| resume_req | output | 1 | Resume signalling requested |
| susp_allow | output | 1 | Suspend permitted |
| iso_sof_wait | output | 1 | Hold ready isochronous packets until the next SOF |
| drive_bus_rst | output | 1 | Host drives reset signalling |

## Verification
The bench writes all-ones and all-zeros patterns in each role. A wrong write mask would show up as a changed status bit in device role, or as a visible connect bit in host role. It clears bit 3 in host role with `hs_granted` at both values, which catches a design that latches speed on the wrong edge or lets the status bit drift. It also drives a host suspend set in the same cycle as `susp_exit`, and a device write while bus reset is present; a design that gave software priority would leave bit 1 set or bit 3 wrong. Protected writes and off-address writes are each checked for an unchanged value, and `wr_err` is checked to last exactly one cycle.

// File: rtl/usbpwr_pkg.sv
// Package: field layout, reset value and role-dependent write masks of the
// power control byte. Assumes the byte layout is fixed by neighbouring logic.
package usbpwr_pkg;

    localparam int REG_W = 8;

    typedef struct packed {
        logic iso_wait;   // bit 7
        logic conn;       // bit 6
        logic hs_en;      // bit 5
        logic hs_stat;    // bit 4
        logic bus_rst;    // bit 3
        logic resume;     // bit 2
        logic susp_stat;  // bit 1
        logic susp_en;    // bit 0
    } pwr_reg_t;

    localparam logic [REG_W-1:0] PWR_RST_VAL   = 8'h20;
    localparam logic [REG_W-1:0] MASK_COMMON   = 8'b0010_0101;
    localparam logic [REG_W-1:0] MASK_DEV_ONLY = 8'b1100_0000;
    localparam logic [REG_W-1:0] MASK_HOST_RST = 8'b0000_1000;

    // Bits whose value a write copies directly in the given role.
    function automatic logic [REG_W-1:0] sw_mask(input logic host);
        return host ? (MASK_COMMON | MASK_HOST_RST) : (MASK_COMMON | MASK_DEV_ONLY);
    endfunction

endpackage

// File: rtl/usbpwr_gate.sv
// Access gate: decodes the register address, applies write protection and
// produces the one-cycle error pulse for blocked writes.
// Assumes bus_wr is a single-cycle strobe qualified by bus_addr.
module usbpwr_gate #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'h1001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_lock,
    output logic              sw_we,
    output logic              wr_err
);

    logic hit;
    logic blocked;

    // Address match and protection split of a write.
    always_comb begin
        hit     = (bus_addr == REG_ADDR);
        sw_we   = bus_wr && hit && !wr_lock;
        blocked = bus_wr && hit && wr_lock;
    end

    // Registered error pulse for a rejected write.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_err <= 1'b0;
        else        wr_err <= blocked;
    end

    a_r7_err_after_block: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == REG_ADDR) && wr_lock) |=> wr_err);

    a_r8_no_err_off_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != REG_ADDR) |=> !wr_err);

endmodule

// File: rtl/usbpwr_bits.sv
// Bit storage: next-state logic of the power byte. It merges software writes
// under the role mask, then applies hardware events, which take priority,
// and finally the role-dependent forcing. Assumes sw_we is already qualified.
module usbpwr_bits
    import usbpwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_role,
    input  logic             sw_we,
    input  logic [REG_W-1:0] wdata,
    input  logic             bus_rst_active,
    input  logic             bus_rst_done,
    input  logic             hs_granted,
    input  logic             susp_enter,
    input  logic             susp_exit,
    output pwr_reg_t         q
);

    logic [REG_W-1:0] mask;
    logic [REG_W-1:0] merged;
    pwr_reg_t         nxt;

    // Compute next value: software merge, then hardware overrides.
    always_comb begin
        mask   = sw_mask(host_role);
        merged = sw_we ? ((q & ~mask) | (wdata & mask)) : q;
        nxt    = pwr_reg_t'(merged);
        if (sw_we && host_role && wdata[1]) nxt.susp_stat = 1'b1;
        if (!host_role) nxt.bus_rst = bus_rst_active;
        if (host_role && q.bus_rst && !nxt.bus_rst) nxt.hs_stat = hs_granted;
        if (!host_role && bus_rst_done) nxt.hs_stat = hs_granted;
        if (!host_role && susp_enter) nxt.susp_stat = 1'b1;
        if (susp_exit) nxt.susp_stat = 1'b0;
        if (host_role) begin
            nxt.iso_wait = 1'b0;
            nxt.conn     = 1'b0;
        end
    end

    // State register with synchronous reset to the documented value.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= pwr_reg_t'(PWR_RST_VAL);
        else        q <= nxt;
    end

    a_r3_host_clears_dev_bits: assert property (@(posedge clk) disable iff (!rst_n)
        host_role |=> (!q.iso_wait && !q.conn));

    a_r4_dev_rst_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !host_role |=> (q.bus_rst == $past(bus_rst_active)));

    a_r6_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        susp_exit |=> !q.susp_stat);

    a_r5_hs_hold_dev: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_role && !bus_rst_done) |=> $stable(q.hs_stat));

    a_r2_sw_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_we |=> ($stable(q.hs_en) && $stable(q.resume) && $stable(q.susp_en)));

endmodule

// File: rtl/usbpwr_ctl_reg.sv
// Top: USB power control register. Joins the access gate and bit storage,
// registers the role for the reset-drive output and fans bits out.
// Assumes all inputs are synchronous to clk.
module usbpwr_ctl_reg
    import usbpwr_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'h1001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_role,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              wr_lock,
    input  logic              bus_rst_active,
    input  logic              bus_rst_done,
    input  logic              hs_granted,
    input  logic              susp_enter,
    input  logic              susp_exit,
    output logic              wr_err,
    output logic              line_en,
    output logic              hs_allow,
    output logic              resume_req,
    output logic              susp_allow,
    output logic              iso_sof_wait,
    output logic              drive_bus_rst
);

    logic     sw_we;
    logic     role_q;
    pwr_reg_t q;

    usbpwr_gate #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) gate_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wr_lock  (wr_lock),
        .sw_we    (sw_we),
        .wr_err   (wr_err)
    );

    usbpwr_bits bits_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_role      (host_role),
        .sw_we          (sw_we),
        .wdata          (bus_wdata),
        .bus_rst_active (bus_rst_active),
        .bus_rst_done   (bus_rst_done),
        .hs_granted     (hs_granted),
        .susp_enter     (susp_enter),
        .susp_exit      (susp_exit),
        .q              (q)
    );

    // Registered role so the reset drive changes with the register.
    always_ff @(posedge clk) begin
        if (!rst_n) role_q <= 1'b0;
        else        role_q <= host_role;
    end

    // Fan register bits out to the controller.
    always_comb begin
        bus_rdata     = q;
        iso_sof_wait  = q.iso_wait;
        line_en       = q.conn;
        hs_allow      = q.hs_en;
        resume_req    = q.resume;
        susp_allow    = q.susp_en;
        drive_bus_rst = role_q && q.bus_rst;
    end

    a_r7_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wr_lock && !host_role && !bus_rst_active && !bus_rst_done
         && !susp_enter && !susp_exit) |=> (bus_rdata == $past(bus_rdata)));

endmodule

// File: tb/usbpwr_ctl_reg_tb_top.sv
// Scoreboard bench: the driver pushes expected results into a queue, and a
// monitor pops and compares them on the falling edge after the update.
module usbpwr_ctl_reg_tb_top;

    localparam logic [15:0] REG = 16'h1001;

    typedef struct {
        int         due;
        logic [7:0] rd;
        logic       err;
        logic       drv;
        string      tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_role = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = REG;
    logic [7:0]  bus_wdata = 8'h00;
    logic        wr_lock = 1'b0;
    logic        bus_rst_active = 1'b0;
    logic        bus_rst_done = 1'b0;
    logic        hs_granted = 1'b0;
    logic        susp_enter = 1'b0;
    logic        susp_exit = 1'b0;
    logic [7:0]  bus_rdata;
    logic        wr_err, line_en, hs_allow, resume_req, susp_allow, iso_sof_wait, drive_bus_rst;

    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    item_t sb_q[$];
    item_t cur;

    always #2.5 clk = ~clk;

    usbpwr_ctl_reg dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_role      (host_role),
        .bus_wr         (bus_wr),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .wr_lock        (wr_lock),
        .bus_rst_active (bus_rst_active),
        .bus_rst_done   (bus_rst_done),
        .hs_granted     (hs_granted),
        .susp_enter     (susp_enter),
        .susp_exit      (susp_exit),
        .wr_err         (wr_err),
        .line_en        (line_en),
        .hs_allow       (hs_allow),
        .resume_req     (resume_req),
        .susp_allow     (susp_allow),
        .iso_sof_wait   (iso_sof_wait),
        .drive_bus_rst  (drive_bus_rst)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item due at this cycle, with R9 output mapping.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            logic [14:0] obs, exp;
            cur = sb_q.pop_front();
            obs = {bus_rdata, wr_err, drive_bus_rst, iso_sof_wait, line_en, hs_allow, resume_req, susp_allow};
            exp = {cur.rd, cur.err, cur.drv, cur.rd[7], cur.rd[6], cur.rd[5], cur.rd[2], cur.rd[0]};
            total++;
            if (obs !== exp) begin
                bad++;
                $display("FAIL %s (R9 mapping): actual=%h expected=%h", cur.tag, obs, exp);
            end
        end
    end

    // Driver side: expect a result after the next edge.
    task automatic put(input logic [7:0] rd, input logic err, input logic drv, input string tag);
        item_t it;
        it.due = cyc + 1;
        it.rd  = rd;
        it.err = err;
        it.drv = drv;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_addr = REG; wr_lock = 1'b0;
        bus_rst_done = 1'b0; susp_enter = 1'b0; susp_exit = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        bus_wr = 1'b1;
        bus_wdata = d;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        put(8'h20, 1'b0, 1'b0, "R1 reset value"); tick();
        rst_n = 1'b1;
        put(8'h20, 1'b0, 1'b0, "R1 after reset"); tick();
        wr(8'hFF); put(8'hE5, 1'b0, 1'b0, "R2 device all ones"); tick();
        wr(8'h00); put(8'h00, 1'b0, 1'b0, "R2 device all zeros"); tick();
        wr(8'h41); put(8'h41, 1'b0, 1'b0, "R2 device connect"); tick();
        wr(8'hFF); wr_lock = 1'b1; put(8'h41, 1'b1, 1'b0, "R7 blocked write"); tick();
        wr_lock = 1'b1; put(8'h41, 1'b0, 1'b0, "R7 error one cycle"); tick();
        wr(8'hFF); bus_addr = 16'h1000; put(8'h41, 1'b0, 1'b0, "R8 other address"); tick();
        wr(8'h41); bus_rst_active = 1'b1; put(8'h49, 1'b0, 1'b0, "R4 R10 device reset tracks"); tick();
        bus_rst_active = 1'b0; bus_rst_done = 1'b1; hs_granted = 1'b1;
        put(8'h51, 1'b0, 1'b0, "R5 device hs latch"); tick();
        hs_granted = 1'b0; put(8'h51, 1'b0, 1'b0, "R5 device hs hold"); tick();
        susp_enter = 1'b1; put(8'h53, 1'b0, 1'b0, "R6 device suspend enter"); tick();
        wr(8'h00); put(8'h12, 1'b0, 1'b0, "R2 status bits kept"); tick();
        susp_exit = 1'b1; put(8'h10, 1'b0, 1'b0, "R6 suspend exit"); tick();
        wr(8'hC0); put(8'hD0, 1'b0, 1'b0, "R2 device iso and connect"); tick();
        host_role = 1'b1; put(8'h10, 1'b0, 1'b0, "R3 host clears device bits"); tick();
        wr(8'hFF); put(8'h3F, 1'b0, 1'b1, "R3 R4 host all ones"); tick();
        wr(8'h35); put(8'h27, 1'b0, 1'b0, "R5 host reset clear hs=0"); tick();
        wr(8'h08); put(8'h0A, 1'b0, 1'b1, "R4 R6 host reset set, susp kept"); tick();
        wr(8'h00); hs_granted = 1'b1; put(8'h12, 1'b0, 1'b0, "R5 host reset clear hs=1"); tick();
        wr(8'h02); susp_exit = 1'b1; put(8'h10, 1'b0, 1'b0, "R10 exit beats host set"); tick();
        bus_rst_active = 1'b1; put(8'h10, 1'b0, 1'b0, "R4 host ignores bus reset"); tick();
        wr(8'h08); wr_lock = 1'b1; put(8'h10, 1'b1, 1'b0, "R7 host blocked write"); tick();
        host_role = 1'b0; bus_rst_active = 1'b0; put(8'h10, 1'b0, 1'b0, "R3 back to device"); tick();
        wr(8'h1A); put(8'h10, 1'b0, 1'b0, "R2 device read-only bits"); tick();
        repeat (2) @(posedge clk);
        #1;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule